// File: doc/BRIEF.md
# Watchdog and Exchange-Awake Reset Generator

This block drives a single reset pulse output for terminal equipment. It has two modes, and a mode-select input chooses between them. In watchdog mode, software must service a timer before it runs out. If it does not, the block raises a sticky interrupt and emits a short reset pulse. In exchange-awake mode, any change on the received command/indication code emits a much longer reset pulse.

All timing counts ticks of an external timebase strobe. The strobe is one clock cycle wide and arrives once every 125 µs. With the default parameters the timeout is 8192 ticks (1024 ms). The short pulse is 1 tick and the long pulse is 128 ticks (16 ms). The block works only after software has set its enable flag, and only a hardware reset clears that flag again.

Top module: `wdg_awake_rst`

## Requirements
- R1: After reset, `wd_en`, `irq` and `rst_pulse` are all 0.
- R2: A write on `en_wr` with `en_wdata` = 1 sets `wd_en`. A write with `en_wdata` = 0 leaves `wd_en` unchanged, and only `rst` clears it.
- R3: While `wd_en` is 0, `irq` and `rst_pulse` stay 0 whatever the other inputs do.
- R4: With `wd_en` = 1 and `sel` = 1 (watchdog mode), expiry occurs on the TIMEOUT_TICKS-th tick after the last restart. From the cycle after that tick, `irq` = 1 and `rst_pulse` = 1, and `rst_pulse` stays 1 for SHORT_TICKS ticks.
- R5: A valid service restarts the watchdog count from zero. A valid service is a `svc_wr` write with `svc_b1` = 1 and `svc_b2` = 0, followed directly, with no other service write in between, by a write with `svc_b1` = 0 and `svc_b2` = 1.
- R6: Any other service sequence, such as a lone second write or two first writes, does not restart the count.
- R7: Any change of `sel` restarts the watchdog count from zero.
- R8: After an expiry, the watchdog reloads and keeps counting. It expires again TIMEOUT_TICKS ticks later unless it is serviced.
- R9: `irq` stays 1 until a cycle with `irq_clr` = 1. If an expiry and a clear fall in the same cycle, the expiry wins.
- R10: With `wd_en` = 1 and `sel` = 0 (exchange-awake mode), a change of `ci_code` sets `rst_pulse` = 1 from the next cycle, and it stays 1 for LONG_TICKS ticks.
- R11: In exchange-awake mode the watchdog does not count, so `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| tick | input | 1 | One-cycle 125 µs timebase strobe |
| en_wr | input | 1 | Write strobe for the enable flag |
| en_wdata | input | 1 | Enable data (only 1 has effect) |
| sel | input | 1 | Mode select: 1 watchdog, 0 exchange-awake |
| svc_wr | input | 1 | Service write strobe |
| svc_b1 | input | 1 | First service bit |
| svc_b2 | input | 1 | Second service bit |
| ci_code | input | CI_W | Received command/indication code |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| wd_en | output | 1 | Enable flag state |
| irq | output | 1 | Sticky watchdog expiry interrupt |
| rst_pulse | output | 1 | Reset pulse output |

## Verification
The bench builds the block with TIMEOUT_TICKS = 20, SHORT_TICKS = 2 and LONG_TICKS = 6, so each expiry, each reload and each pulse edge takes only a few dozen cycles. The short pulse is longer than one tick here. That makes its start and its end separate observable edges, and it sets the short pulse clearly apart from the long one. The small timeout lets the bench compare expiry one tick before and exactly at the limit, after a valid service, after an invalid one and after a mode toggle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic {
        SVC_IDLE  = 1'b0,
        SVC_ARMED = 1'b1
    } svc_state_e;

    typedef struct packed {
        logic wr;
        logic b1;
        logic b2;
    } svc_req_t;

    function automatic logic is_first_step(input svc_req_t r);
        return r.wr && r.b1 && !r.b2;
    endfunction

    function automatic logic is_second_step(input svc_req_t r);
        return r.wr && !r.b1 && r.b2;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wdg_svc_seq.sv
module wdg_svc_seq
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  svc_req_t req,
    output logic     svc_ok
);
    svc_state_e state_q;

    assign svc_ok = (state_q == SVC_ARMED) && is_second_step(req);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state_q <= SVC_IDLE;
        end else if (req.wr) begin
            state_q <= is_first_step(req) ? SVC_ARMED : SVC_IDLE;
        end
    end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam int unsigned CW = cnt_width(TIMEOUT_TICKS);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && !restart && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse
    import wdg_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 1,
    parameter int unsigned LONG_TICKS  = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start_short,
    input  logic start_long,
    output logic active
);
    localparam int unsigned MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int unsigned PW   = cnt_width(MAXT);

    logic [PW-1:0] left_q;

    assign active = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start_long) begin
            left_q <= PW'(LONG_TICKS);
        end else if (start_short) begin
            left_q <= PW'(SHORT_TICKS);
        end else if (tick && active) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdg_awake_rst.sv
module wdg_awake_rst
    import wdg_pkg::*;
#(
    parameter int unsigned CI_W          = 4,
    parameter int unsigned TIMEOUT_TICKS = 8192,
    parameter int unsigned SHORT_TICKS   = 1,
    parameter int unsigned LONG_TICKS    = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            en_wr,
    input  logic            en_wdata,
    input  logic            sel,
    input  logic            svc_wr,
    input  logic            svc_b1,
    input  logic            svc_b2,
    input  logic [CI_W-1:0] ci_code,
    input  logic            irq_clr,
    output logic            wd_en,
    output logic            irq,
    output logic            rst_pulse
);
    logic            en_q, sel_q, irq_q;
    logic [CI_W-1:0] ci_q;
    logic            wd_mode, aw_mode, sel_flip, svc_ok, expire, ci_chg;
    svc_req_t        req;

    assign wd_mode  = en_q && sel;
    assign aw_mode  = en_q && !sel;
    assign sel_flip = (sel != sel_q);
    assign ci_chg   = aw_mode && (ci_code != ci_q);
    assign req      = '{wr: svc_wr, b1: svc_b1, b2: svc_b2};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            sel_q <= sel;
            ci_q  <= ci_code;
            irq_q <= 1'b0;
        end else begin
            if (en_wr && en_wdata) en_q <= 1'b1;
            sel_q <= sel;
            ci_q  <= ci_code;
            if (expire)       irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    wdg_svc_seq u_svc (
        .clk    (clk),
        .rst    (rst),
        .flush  (sel_flip),
        .req    (req),
        .svc_ok (svc_ok)
    );

    wdg_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (wd_mode),
        .restart (sel_flip || svc_ok),
        .tick    (tick),
        .expire  (expire)
    );

    wdg_pulse #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_pulse (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .start_short (expire),
        .start_long  (ci_chg),
        .active      (rst_pulse)
    );

    assign wd_en = en_q;
    assign irq   = irq_q;
endmodule

// File: rtl/wdg_awake_rst_chk.sv
module wdg_awake_rst_chk #(
    parameter int unsigned CI_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            sel,
    input logic [CI_W-1:0] ci_code,
    input logic            irq_clr,
    input logic            wd_en,
    input logic            irq,
    input logic            rst_pulse
);
    p_en_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        wd_en |=> wd_en);

    p_quiet_when_off_r3: assert property (@(posedge clk) disable iff (rst)
        !wd_en |-> (!irq && !rst_pulse));

    p_irq_rise_wd_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (rst_pulse && $past(wd_en && sel)));

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(irq_clr));

    p_ci_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (wd_en && !sel && (ci_code != $past(ci_code))) |=> rst_pulse);
endmodule

bind wdg_awake_rst wdg_awake_rst_chk #(.CI_W(CI_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .ci_code   (ci_code),
    .irq_clr   (irq_clr),
    .wd_en     (wd_en),
    .irq       (irq),
    .rst_pulse (rst_pulse)
);

// File: tb/tb_wdg_awake_rst.sv
`timescale 1ns/1ps
module tb_wdg_awake_rst;
    localparam int CI_W = 4;
    localparam int TO   = 20;
    localparam int SH   = 2;
    localparam int LG   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, en_wr = 1'b0, en_wdata = 1'b0, sel = 1'b1;
    logic svc_wr = 1'b0, svc_b1 = 1'b0, svc_b2 = 1'b0, irq_clr = 1'b0;
    logic [CI_W-1:0] ci_code = '0;
    logic wd_en, irq, rst_pulse;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    wdg_awake_rst #(.CI_W(CI_W), .TIMEOUT_TICKS(TO), .SHORT_TICKS(SH), .LONG_TICKS(LG)) dut (
        .clk(clk), .rst(rst), .tick(tick), .en_wr(en_wr), .en_wdata(en_wdata),
        .sel(sel), .svc_wr(svc_wr), .svc_b1(svc_b1), .svc_b2(svc_b2),
        .ci_code(ci_code), .irq_clr(irq_clr), .wd_en(wd_en), .irq(irq),
        .rst_pulse(rst_pulse)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst = 1'b1; sel = s; tick = 0; en_wr = 0; svc_wr = 0; irq_clr = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_en(input logic d);
        en_wr = 1'b1; en_wdata = d;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic service(input logic b1, input logic b2);
        svc_wr = 1'b1; svc_b1 = b1; svc_b2 = b2;
        @(negedge clk);
        svc_wr = 1'b0;
    endtask

    task automatic t_reset_enable;
        do_reset(1'b1);
        check("R1 wd_en", wd_en, 1'b0);
        check("R1 irq", irq, 1'b0);
        check("R1 rst_pulse", rst_pulse, 1'b0);
        write_en(1'b0);
        check("R2 zero write no set", wd_en, 1'b0);
        write_en(1'b1);
        check("R2 set", wd_en, 1'b1);
        write_en(1'b0);
        check("R2 zero write ignored", wd_en, 1'b1);
    endtask

    task automatic t_disabled;
        do_reset(1'b1);
        ticks(TO + 5);
        check("R3 no irq when disabled", irq, 1'b0);
        sel = 1'b0;
        @(negedge clk);
        ci_code = ci_code + 1'b1;
        @(negedge clk);
        check("R3 no pulse when disabled", rst_pulse, 1'b0);
    endtask

    task automatic t_expire_reload;
        do_reset(1'b1);
        write_en(1'b1);
        ticks(TO - 1);
        check("R4 no expiry before limit", irq, 1'b0);
        check("R4 no pulse before limit", rst_pulse, 1'b0);
        ticks(1);
        check("R4 irq at limit", irq, 1'b1);
        check("R4 pulse at limit", rst_pulse, 1'b1);
        ticks(SH - 1);
        check("R4 pulse held", rst_pulse, 1'b1);
        ticks(1);
        check("R4 pulse ends", rst_pulse, 1'b0);
        check("R9 irq sticky", irq, 1'b1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R9 irq cleared", irq, 1'b0);
        ticks(TO - SH - 1);
        check("R8 no early re-expiry", irq, 1'b0);
        ticks(1);
        check("R8 re-expiry after reload", irq, 1'b1);
    endtask

    task automatic t_service;
        do_reset(1'b1);
        write_en(1'b1);
        ticks(TO - 5);
        service(1'b1, 1'b0);
        service(1'b0, 1'b1);
        ticks(TO - 1);
        check("R5 valid service restarts", irq, 1'b0);
        ticks(1);
        check("R5 expiry after restart", irq, 1'b1);
    endtask

    task automatic t_bad_service;
        do_reset(1'b1);
        write_en(1'b1);
        ticks(10);
        service(1'b0, 1'b1);
        service(1'b1, 1'b0);
        service(1'b1, 1'b0);
        ticks(TO - 11);
        check("R6 bad sequence no restart (before)", irq, 1'b0);
        ticks(1);
        check("R6 bad sequence no restart", irq, 1'b1);
    endtask

    task automatic t_toggle;
        do_reset(1'b1);
        write_en(1'b1);
        ticks(TO - 5);
        sel = 1'b0;
        @(negedge clk);
        sel = 1'b1;
        @(negedge clk);
        check("R7 toggle no awake pulse", rst_pulse, 1'b0);
        ticks(TO - 1);
        check("R7 toggle restarts", irq, 1'b0);
        ticks(1);
        check("R7 expiry after toggle restart", irq, 1'b1);
    endtask

    task automatic t_awake;
        do_reset(1'b0);
        write_en(1'b1);
        ticks(TO + 5);
        check("R11 no watchdog in awake mode", irq, 1'b0);
        check("R11 no pulse without change", rst_pulse, 1'b0);
        ci_code = ci_code ^ 4'h5;
        @(negedge clk);
        check("R10 pulse starts", rst_pulse, 1'b1);
        ticks(LG - 1);
        check("R10 pulse held", rst_pulse, 1'b1);
        ticks(1);
        check("R10 pulse ends", rst_pulse, 1'b0);
    endtask

    initial begin
        t_reset_enable();
        t_disabled();
        t_expire_reload();
        t_service();
        t_bad_service();
        t_toggle();
        t_awake();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule